// File: doc/BRIEF.md
# Oscillator Settle Timer with Interrupt Causes

This block measures the settling period that each of three clock sources needs before it may be used: the main oscillator, the sub oscillator and the PLL. Once a source's enable input goes high, the block counts ticks of a slow reference. The main and PLL waits count high-speed RC ticks. The sub wait counts low-speed RC ticks. The wait ends on the count alone, whatever state the oscillator is really in. At that point the block raises the source's ready flag and latches an interrupt cause for it.

Each reference is modelled as a single-cycle tick enable on the one system clock. A wake-up from stop mode runs the wait again for every enabled source, because all sources halt in stop mode. A software reset works the other way: each enabled source becomes ready at once, with no wait and no interrupt cause.

A small register port holds the following:
- the wait-length codes;
- the interrupt enable mask;
- a status view of the latched causes, which are cleared by writing ones.

A fourth cause comes in from an external frequency-anomaly detector. One interrupt line combines every cause that is both set and enabled.

Top module: `osc_settle_ctrl`

## Requirements
- R1: After hard reset (rst_n low) every ready bit and irq are 0, and all four register addresses read 0.
- R2: A wait lasts 2^(5+code) ticks, where code is a 4-bit field. The main code is bits [3:0] of address 0, the sub code is bits [7:4] of address 0, and the PLL code is bits [3:0] of address 1. The wait starts on the clock edge that first sees the enable high. Ready rises on the edge that registers the last tick.
- R3: Main (osc_en[0]) and PLL (osc_en[2]) count only cycles with tick_hi high. Sub (osc_en[1]) counts only cycles with tick_lo high.
- R4: Dropping an enable clears that ready bit on the next edge and abandons its count. Raising the enable again restarts the count from zero.
- R5: A stop_wake pulse clears the ready bit of every enabled source on the next edge and runs its full wait again.
- R6: A soft_rst pulse sets ready on the next edge for every enabled source, without waiting and without setting any cause. Disabled sources stay not ready.
- R7: A completed wait sets status bit 0 (main), bit 1 (sub) or bit 2 (PLL), on the same edge as its ready bit. An anomaly_evt pulse sets status bit 3.
- R8: Address 3 reads the status. A write to address 3 clears the status bits written as 1. Bits written as 0 are kept, and a write never sets a status bit.
- R9: If a completion and a clear write for the same cause happen on the same edge, the cause stays set.
- R10: irq is high exactly while some status bit and the matching bit of the enable mask at address 2 (bits [3:0]) are both 1. A masked cause stays latched and drives irq as soon as it is enabled.
- R11: Addresses 0, 1 and 2 read back what was written. Bits outside the fields described above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hard reset, clears all state |
| tick_hi | input | 1 | High-speed RC tick enable (main and PLL waits) |
| tick_lo | input | 1 | Low-speed RC tick enable (sub wait) |
| osc_en | input | 3 | Source enables: [0] main, [1] sub, [2] PLL |
| stop_wake | input | 1 | Pulse on wake-up from stop mode |
| soft_rst | input | 1 | Pulse on software reset, skips waits |
| anomaly_evt | input | 1 | Frequency-anomaly detector event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ready | output | 3 | Per-source settled flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound assertions check four rules on every cycle:
- a ready bit is never high unless its enable was high on the previous edge;
- a soft reset readies every enabled source on the next edge;
- a wake-up clears all ready bits;
- every completion or anomaly event is latched, even when a clear arrives in the same cycle, and a full clear with no events drops irq.

Only the directed scenarios can show the following:
- the exact length of each wait and which tick drives it;
- that a re-enable restarts the count from zero;
- that a masked cause stays latched until it is enabled;
- the register read-back.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;

    localparam int NSRC   = 3;
    localparam int NCAUSE = 4;
    localparam int CODE_W = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam int SRC_MAIN = 0;
    localparam int SRC_SUB  = 1;
    localparam int SRC_PLL  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEN   = 2'd0,
        REG_PLEN  = 2'd1,
        REG_MASK  = 2'd2,
        REG_CAUSE = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/settle_chan.sv
module settle_chan #(
    parameter int BASE   = 5,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              wake,
    input  logic              skip,
    input  logic [CODE_W-1:0] code,
    output logic              ready,
    output logic              done
);

    localparam int CNT_W = BASE + (1 << CODE_W) - 1;

    typedef struct packed {
        logic             run;
        logic             rdy;
        logic             en_prev;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [CNT_W:0] target;
    logic [CNT_W:0] cnt_inc;
    logic           hit;

    always_comb begin
        target  = (CNT_W+1)'(1) << (BASE + int'(code));
        cnt_inc = {1'b0, st_q.cnt} + (CNT_W+1)'(1);
        hit     = st_q.run && tick && (cnt_inc >= target);

        st_d         = st_q;
        st_d.en_prev = en;
        done         = 1'b0;

        if (!en) begin
            st_d.run = 1'b0;
            st_d.rdy = 1'b0;
            st_d.cnt = '0;
        end else if (skip) begin
            st_d.run = 1'b0;
            st_d.rdy = 1'b1;
            st_d.cnt = '0;
        end else if (!st_q.en_prev || wake) begin
            st_d.run = 1'b1;
            st_d.rdy = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.run && tick) begin
            if (hit) begin
                st_d.run = 1'b0;
                st_d.rdy = 1'b1;
                st_d.cnt = '0;
                done     = 1'b1;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.rdy;

endmodule

// File: rtl/settle_regs.sv
module settle_regs
    import osc_settle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NCAUSE-1:0] evt,
    output logic [DATA_W-1:0] rd_data,
    output logic [CODE_W-1:0] main_code,
    output logic [CODE_W-1:0] sub_code,
    output logic [CODE_W-1:0] pll_code,
    output logic [NCAUSE-1:0] cause,
    output logic              irq
);

    typedef struct packed {
        logic [CODE_W-1:0] sub_len;
        logic [CODE_W-1:0] main_len;
        logic [CODE_W-1:0] pll_len;
        logic [NCAUSE-1:0] mask;
        logic [NCAUSE-1:0] cause;
    } regs_st_t;

    regs_st_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_LEN: begin
                    rg_d.main_len = wr_data[CODE_W-1:0];
                    rg_d.sub_len  = wr_data[2*CODE_W-1:CODE_W];
                end
                REG_PLEN:  rg_d.pll_len = wr_data[CODE_W-1:0];
                REG_MASK:  rg_d.mask    = wr_data[NCAUSE-1:0];
                REG_CAUSE: rg_d.cause   = rg_q.cause & ~wr_data[NCAUSE-1:0];
                default: ;
            endcase
        end
        rg_d.cause = rg_d.cause | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            REG_LEN:   rd_data = DATA_W'({rg_q.sub_len, rg_q.main_len});
            REG_PLEN:  rd_data = DATA_W'(rg_q.pll_len);
            REG_MASK:  rd_data = DATA_W'(rg_q.mask);
            REG_CAUSE: rd_data = DATA_W'(rg_q.cause);
            default:   rd_data = '0;
        endcase
    end

    assign main_code = rg_q.main_len;
    assign sub_code  = rg_q.sub_len;
    assign pll_code  = rg_q.pll_len;
    assign cause     = rg_q.cause;
    assign irq       = |(rg_q.cause & rg_q.mask);

endmodule

// File: rtl/osc_settle_ctrl.sv
module osc_settle_ctrl
    import osc_settle_pkg::*;
#(
    parameter int BASE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_hi,
    input  logic              tick_lo,
    input  logic [NSRC-1:0]   osc_en,
    input  logic              stop_wake,
    input  logic              soft_rst,
    input  logic              anomaly_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NSRC-1:0]   ready,
    output logic              irq
);

    logic [NSRC-1:0]   done_w;
    logic [NCAUSE-1:0] cause_w;
    logic [CODE_W-1:0] main_code;
    logic [CODE_W-1:0] sub_code;
    logic [CODE_W-1:0] pll_code;

    for (genvar i = 0; i < NSRC; i++) begin : g_chan
        logic              tick_sel;
        logic [CODE_W-1:0] code_sel;
        if (i == SRC_SUB) begin : g_lo
            assign tick_sel = tick_lo;
            assign code_sel = sub_code;
        end else if (i == SRC_MAIN) begin : g_main
            assign tick_sel = tick_hi;
            assign code_sel = main_code;
        end else begin : g_pll
            assign tick_sel = tick_hi;
            assign code_sel = pll_code;
        end

        settle_chan #(
            .BASE   (BASE),
            .CODE_W (CODE_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (osc_en[i]),
            .tick  (tick_sel),
            .wake  (stop_wake),
            .skip  (soft_rst),
            .code  (code_sel),
            .ready (ready[i]),
            .done  (done_w[i])
        );
    end

    settle_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .evt       ({anomaly_evt, done_w}),
        .rd_data   (rd_data),
        .main_code (main_code),
        .sub_code  (sub_code),
        .pll_code  (pll_code),
        .cause     (cause_w),
        .irq       (irq)
    );

endmodule

// File: rtl/osc_settle_ctrl_chk.sv
module osc_settle_ctrl_chk
    import osc_settle_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   osc_en,
    input logic [NSRC-1:0]   ready,
    input logic              stop_wake,
    input logic              soft_rst,
    input logic              anomaly_evt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic [NSRC-1:0]   done_w,
    input logic [NCAUSE-1:0] cause_w
);

    // R4: a ready bit may only be high if its enable was high on the previous edge
    p_ready_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((ready & ~$past(osc_en)) == '0));

    // R6: software reset readies every enabled source on the next edge
    p_soft_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((ready & $past(osc_en)) == $past(osc_en)));

    // R5: a wake-up without software reset clears all ready flags
    p_wake_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wake && !soft_rst) |=> (ready == '0));

    // R7 and R9: completions are latched even against a same-cycle clear
    p_done_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_w) |=> ((cause_w[NSRC-1:0] & $past(done_w)) == $past(done_w)));

    // R7: anomaly events are latched in bit 3
    p_anomaly_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly_evt |=> cause_w[NCAUSE-1]);

    // R10: clearing every cause with no new events leaves irq low
    p_full_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(REG_CAUSE) && wr_data[NCAUSE-1:0] == '1
         && done_w == '0 && !anomaly_evt) |=> !irq);

endmodule

bind osc_settle_ctrl osc_settle_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en      (osc_en),
    .ready       (ready),
    .stop_wake   (stop_wake),
    .soft_rst    (soft_rst),
    .anomaly_evt (anomaly_evt),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .irq         (irq),
    .done_w      (done_w),
    .cause_w     (cause_w)
);

// File: tb/osc_settle_ctrl_test.sv
module osc_settle_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_hi = 1'b1;
    logic       tick_lo = 1'b0;
    logic [2:0] osc_en = '0;
    logic       stop_wake = 1'b0;
    logic       soft_rst = 1'b0;
    logic       anomaly_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [2:0] ready;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done_all = 1'b0;

    always #5 clk = ~clk;

    osc_settle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick_hi(tick_hi), .tick_lo(tick_lo),
        .osc_en(osc_en), .stop_wake(stop_wake), .soft_rst(soft_rst),
        .anomaly_evt(anomaly_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ready(ready), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 ready", int'(ready), 0);
        check("R1 irq", int'(irq), 0);
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), d);
            check("R1 regs", int'(d), 0);
        end
    endtask

    task automatic t_main_wait();
        logic [7:0] d;
        osc_en[0] = 1'b1;
        cyc(32);
        check("R2 main early", int'(ready[0]), 0);
        cyc(1);
        check("R2 main ready", int'(ready[0]), 1);
        reg_rd(2'd3, d);
        check("R7 main cause", int'(d), 8'h01);
        reg_wr(2'd3, 8'h01);
    endtask

    task automatic t_pll_wait();
        logic [7:0] d;
        reg_wr(2'd1, 8'h01);
        tick_hi = 1'b0;
        osc_en[2] = 1'b1;
        cyc(10);
        check("R3 pll no tick", int'(ready[2]), 0);
        tick_hi = 1'b1;
        cyc(63);
        check("R2 pll early", int'(ready[2]), 0);
        cyc(1);
        check("R2 pll ready", int'(ready[2]), 1);
        reg_rd(2'd3, d);
        check("R7 pll cause", int'(d), 8'h04);
        reg_wr(2'd3, 8'h04);
        osc_en[2] = 1'b0;
        cyc(1);
    endtask

    task automatic t_sub_wait();
        logic [7:0] d;
        osc_en[1] = 1'b1;
        cyc(1);
        for (int i = 0; i < 31; i++) begin
            tick_lo = 1'b1; cyc(1); tick_lo = 1'b0; cyc(1);
        end
        cyc(3);
        check("R3 sub early", int'(ready[1]), 0);
        tick_lo = 1'b1; cyc(1); tick_lo = 1'b0;
        check("R3 sub ready", int'(ready[1]), 1);
        reg_rd(2'd3, d);
        check("R7 sub cause", int'(d), 8'h02);
        reg_wr(2'd3, 8'h02);
        osc_en[1] = 1'b0;
        cyc(1);
    endtask

    task automatic t_disable_restart();
        osc_en[0] = 1'b0;
        cyc(1);
        check("R4 drop", int'(ready[0]), 0);
        osc_en[0] = 1'b1;
        cyc(20);
        osc_en[0] = 1'b0;
        cyc(1);
        osc_en[0] = 1'b1;
        cyc(32);
        check("R4 restart from zero", int'(ready[0]), 0);
        cyc(1);
        check("R4 restart ready", int'(ready[0]), 1);
        reg_wr(2'd3, 8'h0F);
    endtask

    task automatic t_wake();
        logic [7:0] d;
        stop_wake = 1'b1;
        cyc(1);
        stop_wake = 1'b0;
        check("R5 wake drop", int'(ready[0]), 0);
        cyc(31);
        check("R5 wake early", int'(ready[0]), 0);
        cyc(1);
        check("R5 wake ready", int'(ready[0]), 1);
        reg_rd(2'd3, d);
        check("R5 wake cause", int'(d), 8'h01);
        reg_wr(2'd3, 8'h0F);
    endtask

    task automatic t_soft();
        logic [7:0] d;
        osc_en[0] = 1'b0;
        cyc(1);
        osc_en[0] = 1'b1;
        cyc(5);
        soft_rst = 1'b1;
        cyc(1);
        soft_rst = 1'b0;
        check("R6 skip ready", int'(ready), 3'b001);
        reg_rd(2'd3, d);
        check("R6 no cause", int'(d), 0);
        cyc(40);
        reg_rd(2'd3, d);
        check("R6 no late cause", int'(d), 0);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        osc_en[0] = 1'b0;
        cyc(1);
        osc_en[0] = 1'b1;
        cyc(32);
        reg_wr(2'd3, 8'h01);
        check("R9 ready", int'(ready[0]), 1);
        reg_rd(2'd3, d);
        check("R9 set wins", int'(d), 8'h01);
        reg_wr(2'd3, 8'h00);
        reg_rd(2'd3, d);
        check("R8 zero write keeps", int'(d), 8'h01);
        reg_wr(2'd3, 8'h01);
        reg_wr(2'd3, 8'h0E);
        reg_rd(2'd3, d);
        check("R8 no set by write", int'(d), 0);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        anomaly_evt = 1'b1;
        cyc(1);
        anomaly_evt = 1'b0;
        reg_rd(2'd3, d);
        check("R7 anomaly cause", int'(d), 8'h08);
        check("R10 masked", int'(irq), 0);
        reg_wr(2'd2, 8'h01);
        check("R10 wrong mask", int'(irq), 0);
        reg_wr(2'd2, 8'h08);
        check("R10 enabled", int'(irq), 1);
        reg_wr(2'd3, 8'h08);
        check("R10 cleared", int'(irq), 0);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        reg_wr(2'd0, 8'hA5);
        reg_rd(2'd0, d);
        check("R11 len reg", int'(d), 8'hA5);
        reg_wr(2'd1, 8'hF3);
        reg_rd(2'd1, d);
        check("R11 pll reg", int'(d), 8'h03);
        reg_wr(2'd2, 8'hFF);
        reg_rd(2'd2, d);
        check("R11 mask reg", int'(d), 8'h0F);
    endtask

    initial begin
        fork
            begin
                cyc(3);
                t_reset();
                rst_n = 1'b1;
                cyc(2);
                t_main_wait();
                t_pll_wait();
                t_sub_wait();
                t_disable_restart();
                t_wake();
                t_soft();
                t_collision();
                t_irq();
                t_regmap();
                done_all = 1'b1;
            end
            begin
                cyc(20000);
            end
        join_any
        if (!done_all) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule